// File: doc/BRIEF.md
# Flash Write Cycle Sequencer

This block is the timing engine that sits behind the modifying commands of a small serial flash. Once the command logic has framed a request, it hands the request to the sequencer. There are three kinds: program one to a full page of bytes, erase one sector, or rewrite the status register. The sequencer then holds a busy flag for the self-timed duration of that operation and updates the storage while the flag is high. Durations are parameters in system clock cycles, so a bench can use short values and a chip can use real ones.

Program time grows with the byte count. Each byte takes one fixed byte slot, and each byte is committed at the end of its own slot. An erase sets every byte of the addressed sector to 0xFF when its cycle ends. A status write is a single combined cycle of fixed length, and the new value appears when that cycle ends. Programming can only clear bits: a programmed byte becomes the old value ANDed with the new data. Bytes of a page program come from a page buffer that the command logic loads beforehand. The buffer and the array both live in this block, and the array has a combinational read port.

Control is one state machine with four states:
- ST_IDLE: not busy. It moves to ST_PROG, ST_ERASE or ST_SRWR when it accepts a request.
- ST_PROG: counts byte slots. It returns to ST_IDLE when the slot of the last byte ends.
- ST_ERASE: returns to ST_IDLE when the erase time runs out.
- ST_SRWR: returns to ST_IDLE when the status write time runs out.

Top module: `flash_write_sequencer`

## Requirements
- R1: After reset, busy_o is 0, status_o is 0x00 and every array byte reads 0xFF.
- R2: In the idle state, a req_valid pulse with req_op 2'b00 (program), 2'b01 (erase) or 2'b10 (status write) is accepted, and busy_o is 1 from the next cycle.
- R3: A program with req_len = n-1 (n from 1 to PAGE_BYTES) keeps busy_o high for exactly n*BYTE_CYCLES cycles.
- R4: Program byte i goes into the page selected by req_addr, at column (start column + i) mod PAGE_BYTES, so it wraps within the page. The column is the low log2(PAGE_BYTES) address bits. The byte becomes old & buffer[i], and it is visible on rd_data (i+1)*BYTE_CYCLES cycles after acceptance and not one cycle earlier.
- R5: An erase keeps busy_o high for ERASE_CYCLES cycles. It then sets every byte of the sector selected by the top address bits to 0xFF. The other sector is unchanged, and no byte changes before the erase cycle ends.
- R6: A status write keeps busy_o high for SR_CYCLES cycles. status_o[7:1] then takes req_data[6:0] and holds its old value until then.
- R7: status_o[0] always equals busy_o.
- R8: A request presented while busy_o is 1 is ignored. It adds no busy time and changes neither the array nor the status register.
- R9: A page buffer write (buf_we) while busy_o is 1 is ignored.
- R10: A request with req_op 2'b11 is ignored and leaves busy_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe from the command logic |
| req_op | input | 2 | 00 program, 01 sector erase, 10 status write, 11 none |
| req_addr | input | ADDR_W | Start address (program) or any address in the sector (erase) |
| req_len | input | COL_W | Program byte count minus one |
| req_data | input | 7 | New value for status bits 7:1 |
| buf_we | input | 1 | Page buffer write strobe |
| buf_idx | input | COL_W | Page buffer byte index |
| buf_data | input | 8 | Page buffer write data |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| busy_o | output | 1 | Self-timed cycle in progress |
| status_o | output | 8 | Status register; bit 0 is busy |

## Verification
A byte-slot counter that reloads wrongly, or a byte index that advances wrongly, shows up at the ports in one of two ways. Either the busy pulse length is off, and this is visible on the cycle busy_o falls. Or a programmed byte lands in the wrong column or at the wrong time, and this is visible on rd_data one cycle after that byte's slot ends. A latched operation that is overwritten while busy shows up as an extra or stretched busy pulse, or as a changed array byte or status value, by the end of the running cycle. The bench keeps a model of the array and samples the first committed byte on both sides of its commit edge, so a one-cycle timing slip is caught.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [1:0] {
        OP_PROGRAM = 2'b00,
        OP_ERASE   = 2'b01,
        OP_STATUS  = 2'b10,
        OP_NONE    = 2'b11
    } wr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PROG  = 2'b01,
        ST_ERASE = 2'b10,
        ST_SRWR  = 2'b11
    } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
// Down counter: loads a cycle count, reports zero when the count runs out.
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/page_buffer.sv
// Holds the bytes of one page program.
module page_buffer #(
    parameter int COL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [COL_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [COL_W-1:0] ridx,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 1 << COL_W;

    logic [7:0] buf_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) buf_q[i] <= 8'hFF;
        end else if (we) begin
            buf_q[widx] <= wdata;
        end
    end

    assign rdata = buf_q[ridx];
endmodule

// File: rtl/flash_array.sv
// Byte array. A program can only clear bits; an erase sets one sector to 0xFF.
module flash_array #(
    parameter int ADDR_W = 11,
    parameter int SEC_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_en,
    input  logic [SEC_W-1:0]  erase_sector,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH        = 1 << ADDR_W;
    localparam int SECTOR_BYTES = DEPTH >> SEC_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            if (erase_en) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if ((i / SECTOR_BYTES) == int'(erase_sector)) mem_q[i] <= 8'hFF;
                end
            end
            if (prog_en) begin
                mem_q[prog_addr] <= mem_q[prog_addr] & prog_data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/flash_write_sequencer.sv
module flash_write_sequencer
    import flash_seq_pkg::*;
#(
    parameter int PAGE_BYTES       = 128,
    parameter int PAGES_PER_SECTOR = 8,
    parameter int SECTOR_COUNT     = 2,
    parameter int BYTE_CYCLES      = 4,
    parameter int ERASE_CYCLES     = 40,
    parameter int SR_CYCLES        = 12,
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int ADDR_W = $clog2(PAGE_BYTES * PAGES_PER_SECTOR * SECTOR_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [COL_W-1:0]  req_len,
    input  logic [6:0]        req_data,
    input  logic              buf_we,
    input  logic [COL_W-1:0]  buf_idx,
    input  logic [7:0]        buf_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy_o,
    output logic [7:0]        status_o
);
    localparam int SEC_W   = $clog2(SECTOR_COUNT);
    localparam int MAX_A   = (BYTE_CYCLES > ERASE_CYCLES) ? BYTE_CYCLES : ERASE_CYCLES;
    localparam int MAX_CYC = (MAX_A > SR_CYCLES) ? MAX_A : SR_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e        state_q, state_d;
    wr_op_e            op_in;
    logic              accept;
    logic              timer_load, timer_zero;
    logic [CNT_W-1:0]  timer_val;
    logic [ADDR_W-1:0] addr_q;
    logic [COL_W-1:0]  last_q, idx_q, col_sum;
    logic [6:0]        sr_new_q, sr_q;
    logic              prog_en, erase_en, sr_commit;
    logic [ADDR_W-1:0] prog_addr;
    logic [7:0]        buf_rdata;

    assign op_in  = wr_op_e'(req_op);
    assign accept = req_valid && (state_q == ST_IDLE) && (op_in != OP_NONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op_in)
                        OP_PROGRAM: state_d = ST_PROG;
                        OP_ERASE:   state_d = ST_ERASE;
                        OP_STATUS:  state_d = ST_SRWR;
                        default:    state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PROG:  if (timer_zero && (idx_q == last_q)) state_d = ST_IDLE;
            ST_ERASE: if (timer_zero) state_d = ST_IDLE;
            ST_SRWR:  if (timer_zero) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        prog_en    = (state_q == ST_PROG)  && timer_zero;
        erase_en   = (state_q == ST_ERASE) && timer_zero;
        sr_commit  = (state_q == ST_SRWR)  && timer_zero;
        timer_load = accept || (prog_en && (idx_q != last_q));
        timer_val  = CNT_W'(BYTE_CYCLES - 1);
        if (accept) begin
            unique case (op_in)
                OP_ERASE:  timer_val = CNT_W'(ERASE_CYCLES - 1);
                OP_STATUS: timer_val = CNT_W'(SR_CYCLES - 1);
                default:   timer_val = CNT_W'(BYTE_CYCLES - 1);
            endcase
        end
        col_sum   = addr_q[COL_W-1:0] + idx_q;
        prog_addr = {addr_q[ADDR_W-1:COL_W], col_sum};
        status_o  = {sr_q, busy_o};
    end

    // Request latch, byte index and status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            last_q   <= '0;
            idx_q    <= '0;
            sr_new_q <= '0;
            sr_q     <= '0;
        end else begin
            if (accept) begin
                addr_q   <= req_addr;
                last_q   <= (op_in == OP_PROGRAM) ? req_len : '0;
                idx_q    <= '0;
                sr_new_q <= req_data;
            end else if (prog_en && (idx_q != last_q)) begin
                idx_q <= idx_q + 1'b1;
            end
            if (sr_commit) sr_q <= sr_new_q;
        end
    end

    seq_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .zero     (timer_zero)
    );

    page_buffer #(.COL_W(COL_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we && !busy_o),
        .widx  (buf_idx),
        .wdata (buf_data),
        .ridx  (idx_q),
        .rdata (buf_rdata)
    );

    flash_array #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_en      (prog_en),
        .prog_addr    (prog_addr),
        .prog_data    (buf_rdata),
        .erase_en     (erase_en),
        .erase_sector (addr_q[ADDR_W-1 -: SEC_W]),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );
endmodule

// File: rtl/flash_write_sequencer_chk.sv
module flash_write_sequencer_chk #(
    parameter int COL_W  = 7,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              busy_o,
    input logic [7:0]        status_o,
    input logic [ADDR_W-1:0] addr_q,
    input logic [COL_W-1:0]  idx_q,
    input logic [COL_W-1:0]  last_q,
    input logic              timer_zero
);
    // R2: an accepted request raises busy on the next cycle
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy_o && req_op != 2'b11) |=> busy_o);

    // R10: an empty request leaves the block idle
    assert_none_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy_o && req_op == 2'b11) |=> !busy_o);

    // R8: the latched request does not change during a cycle
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(addr_q) && $stable(last_q)));

    // R6: status bits do not move while a cycle is still running
    assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || $stable(status_o[7:1])));

    // R3: the byte index never passes the last byte
    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= last_q);

    // R3: busy ends only when the cycle timer has run out
    assert_end_on_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(timer_zero));
endmodule

bind flash_write_sequencer flash_write_sequencer_chk #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .busy_o     (busy_o),
    .status_o   (status_o),
    .addr_q     (addr_q),
    .idx_q      (idx_q),
    .last_q     (last_q),
    .timer_zero (timer_zero)
);

// File: tb/flash_write_sequencer_tb.sv
module flash_write_sequencer_tb;
    localparam int PB = 128, PPS = 8, SC = 2;
    localparam int BC = 4, EC = 40, SRC = 12;
    localparam int COL_W = $clog2(PB);
    localparam int ADDR_W = $clog2(PB * PPS * SC);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SEC_BYTES = DEPTH / SC;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [1:0] req_op = 2'b11;
    logic [ADDR_W-1:0] req_addr = '0, rd_addr = '0;
    logic [COL_W-1:0] req_len = '0, buf_idx = '0;
    logic [6:0] req_data = '0;
    logic buf_we = 0;
    logic [7:0] buf_data = '0, rd_data, status_o;
    logic busy_o;

    int tests = 0, fails = 0;
    bit done = 0;
    int exp_q[$];
    int run_len = 0;
    logic [7:0] ref_mem [DEPTH];
    logic [7:0] ref_buf [PB];
    logic [6:0] ref_sr = '0;

    always #2 clk = ~clk;

    flash_write_sequencer #(.PAGE_BYTES(PB), .PAGES_PER_SECTOR(PPS), .SECTOR_COUNT(SC),
        .BYTE_CYCLES(BC), .ERASE_CYCLES(EC), .SR_CYCLES(SRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy_o(busy_o), .status_o(status_o));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: measure each busy pulse and compare with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) run_len++;
            else if (run_len > 0) begin
                if (exp_q.size() == 0) check(0, "R8 unexpected busy pulse", run_len, 0);
                else begin
                    automatic int e = exp_q.pop_front();
                    check(run_len == e, "R3/R5/R6 busy length", run_len, e);
                end
                run_len = 0;
            end
        end
    end

    task automatic load_buf(input int idx, input logic [7:0] d);
        @(negedge clk);
        if (!busy_o) ref_buf[idx] = d;   // R9: writes while busy are dropped
        buf_we = 1; buf_idx = COL_W'(idx); buf_data = d;
        @(negedge clk);
        buf_we = 0;
    endtask

    // Driver: issues a request at a negedge and pushes the expected pulse length
    task automatic issue(input logic [1:0] op, input int addr, input int len, input logic [6:0] d);
        @(negedge clk);
        if (!busy_o && op != 2'b11) begin
            if (op == 2'b00) begin
                exp_q.push_back((len + 1) * BC);
                for (int i = 0; i <= len; i++) begin
                    automatic int a = (addr & ~(PB - 1)) | ((addr + i) & (PB - 1));
                    ref_mem[a] = ref_mem[a] & ref_buf[i];
                end
            end else if (op == 2'b01) begin
                exp_q.push_back(EC);
                for (int i = 0; i < DEPTH; i++)
                    if (i / SEC_BYTES == addr / SEC_BYTES) ref_mem[i] = 8'hFF;
            end else begin
                exp_q.push_back(SRC);
                ref_sr = d;
            end
        end
        req_valid = 1; req_op = op; req_addr = ADDR_W'(addr);
        req_len = COL_W'(len); req_data = d;
        @(negedge clk);
        req_valid = 0; req_op = 2'b11;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_mem(input int a, input string tag);
        rd_addr = ADDR_W'(a);
        #1;
        check(rd_data == ref_mem[a], tag, rd_data, ref_mem[a]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        for (int i = 0; i < PB; i++) ref_buf[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(busy_o == 0, "R1 busy after reset", busy_o, 0);
        check(status_o == 8'h00, "R1 status after reset", status_o, 0);
        check_mem(0, "R1 array erased");
        check_mem(DEPTH - 1, "R1 array erased top");

        // R2 R3 R4: three-byte program with commit timing of byte 0
        load_buf(0, 8'h0F); load_buf(1, 8'hA5); load_buf(2, 8'h3C);
        issue(2'b00, 5, 2, '0);
        check(busy_o == 1, "R2 busy after accept", busy_o, 1);
        rd_addr = ADDR_W'(5);
        repeat (BC - 1) @(negedge clk);
        check(rd_data == 8'hFF, "R4 byte0 not yet committed", rd_data, 8'hFF);
        @(negedge clk);
        check(rd_data == 8'h0F, "R4 byte0 committed at slot end", rd_data, 8'h0F);
        wait_idle();
        for (int a = 4; a <= 8; a++) check_mem(a, "R4 program data");

        // R4: wrap inside the page
        load_buf(0, 8'h12); load_buf(1, 8'h34); load_buf(2, 8'h56); load_buf(3, 8'h78);
        issue(2'b00, 16'h0FE, 3, '0);
        wait_idle();
        check_mem(16'h0FE, "R4 wrap col126"); check_mem(16'h0FF, "R4 wrap col127");
        check_mem(16'h080, "R4 wrap col0");   check_mem(16'h081, "R4 wrap col1");
        check_mem(16'h100, "R4 next page untouched");

        // R4: programming only clears bits (byte mode)
        load_buf(0, 8'hF0);
        issue(2'b00, 5, 0, '0);
        wait_idle();
        check_mem(5, "R4 AND with old value");

        // R8 R9: requests and buffer writes during a program are dropped
        load_buf(0, 8'h11); load_buf(1, 8'h22); load_buf(2, 8'h33); load_buf(3, 8'h44);
        issue(2'b00, 16'h600, 3, '0);
        load_buf(3, 8'h00);
        issue(2'b01, 16'h010, 0, '0);
        issue(2'b10, 0, 0, 7'h55);
        wait_idle();
        check_mem(16'h603, "R9 buffer write while busy ignored");
        check_mem(5, "R8 erase while busy ignored");
        check(status_o == 8'h00, "R8 status write while busy ignored", status_o, 0);

        // R6 R7: status write
        issue(2'b10, 0, 0, 7'h53);
        check(status_o == 8'h01, "R7 busy bit / R6 old bits during cycle", status_o, 8'h01);
        repeat (SRC - 1) @(negedge clk);
        check(status_o == 8'h01, "R6 old bits until cycle end", status_o, 8'h01);
        @(negedge clk);
        check(status_o == 8'hA6, "R6 new bits after cycle", status_o, 8'hA6);

        // R10: empty request
        issue(2'b11, 0, 0, 7'h00);
        check(busy_o == 0, "R10 op 11 ignored", busy_o, 0);
        check(status_o == {ref_sr, 1'b0}, "R10 status unchanged", status_o, {ref_sr, 1'b0});

        // R5: erase sector 0, nothing changes before the end
        issue(2'b01, 16'h123, 0, '0);
        rd_addr = ADDR_W'(5);
        repeat (EC - 1) @(negedge clk);
        check(rd_data == 8'h00, "R5 no change before erase end", rd_data, 8'h00);
        @(negedge clk);
        check(rd_data == 8'hFF, "R5 erased at cycle end", rd_data, 8'hFF);
        wait_idle();
        check_mem(16'h0FE, "R5 sector0 erased");
        check_mem(16'h601, "R5 sector1 kept");

        // R5: erase sector 1
        issue(2'b01, DEPTH - 1, 0, '0);
        wait_idle();
        check_mem(16'h603, "R5 sector1 erased");

        // Full sweep against the model and scoreboard drain
        begin
            automatic int bad = 0;
            for (int a = 0; a < DEPTH; a++) begin
                rd_addr = ADDR_W'(a);
                #0.1;
                if (rd_data != ref_mem[a]) bad++;
            end
            check(bad == 0, "R4/R5 array sweep mismatches", bad, 0);
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R8 missing busy pulses", exp_q.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule